// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This block watches twelve general-purpose input pins through two independent event channels. Each channel is steered onto one pin and reacts to one chosen edge of it. On an event the channel stores a stamp: either the value of a free-running timer or a real-time-clock stamp. Both arrive as inputs from counters outside the block. A channel works in one of two modes. In capture mode every qualifying edge is an event. In count mode the channel counts qualifying edges and raises an event only after a programmed number of periods.

A single 32-bit control word configures both channels. Each channel holds its last stored stamp, a sticky pending flag and an overflow flag. One interrupt line combines the pending flags of the channels whose interrupt is enabled. Software clears a channel's flags by pulsing its bit of a write-one-to-clear input.

Top module: `evcap_dual`

## Requirements
- R1: Control word layout. Channel 0 occupies bits 13:0 and channel 1 occupies bits 27:14. Within a channel's 14-bit slice: [3:0] pin select, [4] edge select, [5] mode, [6] interrupt enable, [12:7] period limit N, [13] stamp source. Bits 31:28 have no effect. A write with `cfg_we` high takes effect at that clock edge.
- R2: After reset the control word is zero. All stored stamps, pending flags, overflow flags and `irq` are zero.
- R3: A pin select of 1 to 12 routes `gpio_in[sel-1]` to the channel. A select of 0, 13, 14 or 15 disables the channel, which then produces no events and leaves its stored stamp unchanged.
- R4: Edge select 0 makes rising edges of the routed pin qualify, and falling edges are ignored. Edge select 1 makes falling edges qualify, and rising edges are ignored.
- R5: In capture mode (mode bit 0) every qualifying edge is an event. If the pin takes its new level before clock edge k, the stamp and the pending flag are updated at clock edge k+2 and not earlier.
- R6: An event stores `timer_val` when the stamp source bit is 0, and `rtc_val` when it is 1. The value stored is the one present at the clock edge that records the event.
- R7: In count mode (mode bit 1) the event occurs on qualifying edge number N+1 after the period counter was last cleared. The counter then restarts from zero. With N=0, every qualifying edge is an event.
- R8: Any write of the control word clears both period counters, so edges counted before the write do not count toward the next event.
- R9: Each pending flag is set on every event of its channel, whatever the interrupt enable. It is cleared by a 1 on the channel's bit of `clr_pend` (bit 0 for channel 0, bit 1 for channel 1). An event in the same cycle as a clear leaves the flag set.
- R10: `irq` is high exactly when some channel has both its pending flag and its interrupt enable set.
- R11: An event on a channel whose pending flag is already set, and not being cleared, overwrites the stored stamp and sets the overflow flag. A clear via `clr_pend` resets the overflow flag together with the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| gpio_in | input | 12 | Asynchronous input pins |
| timer_val | input | 32 | Free-running timer value |
| rtc_val | input | 32 | Real-time-clock stamp |
| clr_pend | input | 2 | Write-one-to-clear for pending and overflow, one bit per channel |
| cap0 | output | 32 | Stored stamp of channel 0 |
| cap1 | output | 32 | Stored stamp of channel 1 |
| pend | output | 2 | Pending flags, bit c for channel c |
| ovf | output | 2 | Overflow flags, bit c for channel c |
| irq | output | 1 | Combined interrupt |

## Verification
Three registers sit between a pin change and a stored stamp: two synchroniser stages and the flag register. A level driven before clock edge k therefore shows on `pend` and the stamp outputs after edge k+2. The bench samples the outputs one negative half-cycle before that edge and again just after it to pin down that latency. Flag clears and control writes land at the edge after they are driven, and `irq` follows `pend` with no extra delay. The bench therefore drives every input on the falling clock edge and reads outputs on the next falling edge, after those edges have passed. A monitor pops the expected channel and stamp from a queue whenever a pending flag rises. Edges that must be ignored are checked by waiting past the full latency and confirming that no flag rose.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  localparam int SEL_W  = 4;
  localparam int PMAX_W = 6;
  localparam int CFG_W  = 14;

  // one channel slice of the control word, MSB first
  typedef struct packed {
    logic              stamp_rtc;
    logic [PMAX_W-1:0] pmax;
    logic              irq_en;
    logic              count_mode;
    logic              fall_sel;
    logic [SEL_W-1:0]  pin_sel;
  } chan_cfg_t;

  // pin select codes 1..npins route a pin, every other code disables
  function automatic logic sel_used(input logic [SEL_W-1:0] sel, input int npins);
    return (sel != '0) && (int'(sel) <= npins);
  endfunction

  // true on the qualifying edge that closes a counting window
  function automatic logic period_done(input logic [PMAX_W-1:0] cnt,
                                       input logic [PMAX_W-1:0] lim);
    return cnt == lim;
  endfunction

endpackage

// File: rtl/evcap_sync_bank.sv
module evcap_sync_bank #(
  parameter int NPINS  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  // STAGES synchroniser flops plus one history flop per pin
  logic [NPINS-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pins_in;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign rise = stg[STAGES-1] & ~stg[STAGES];
  assign fall = ~stg[STAGES-1] & stg[STAGES];
endmodule

// File: rtl/evcap_period.sv
module evcap_period
  import evcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              count_mode,
  input  logic [PMAX_W-1:0] pmax,
  input  logic              edge_in,
  output logic              fire
);
  logic [PMAX_W-1:0] cnt_q;

  always_comb begin
    if (count_mode) fire = edge_in && period_done(cnt_q, pmax);
    else            fire = edge_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr || !count_mode)   cnt_q <= '0;
    else if (edge_in)              cnt_q <= period_done(cnt_q, pmax) ? '0 : cnt_q + 1'b1;
  end

  // R7: the count never passes the programmed limit
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pmax);

  // R8: a control write leaves the counter at zero
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
endmodule

// File: rtl/evcap_channel.sv
module evcap_channel
  import evcap_pkg::*;
#(
  parameter int NPINS   = 12,
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  chan_cfg_t          cfg,
  input  logic               cfg_we,
  input  logic [NPINS-1:0]   pin_rise,
  input  logic [NPINS-1:0]   pin_fall,
  input  logic [STAMP_W-1:0] timer_val,
  input  logic [STAMP_W-1:0] rtc_val,
  input  logic               clr,
  output logic [STAMP_W-1:0] cap_q,
  output logic               pend_q,
  output logic               ovf_q
);
  logic used;
  logic edge_sel;
  logic evt;

  assign used = sel_used(cfg.pin_sel, NPINS);

  always_comb begin
    edge_sel = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (used && int'(cfg.pin_sel) == i + 1)
        edge_sel = cfg.fall_sel ? pin_fall[i] : pin_rise[i];
    end
  end

  evcap_period u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cfg_we),
    .count_mode (cfg.count_mode),
    .pmax       (cfg.pmax),
    .edge_in    (edge_sel),
    .fire       (evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (evt) cap_q <= cfg.stamp_rtc ? rtc_val : timer_val;
      if (evt)      pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      if (evt)      ovf_q <= ovf_q | (pend_q && !clr);
      else if (clr) ovf_q <= 1'b0;
    end
  end

  // R3: a disabled channel keeps its stamp
  assert_unused_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !used |=> $stable(cap_q));

  // R5: in capture mode a selected edge raises pending next cycle
  assert_cap_sets_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && !cfg.count_mode) |=> pend_q);

  // R9: pending only rises after an event
  assert_pend_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(evt));

  // R11: overflow implies pending, and a doubled event sets overflow
  assert_ovf_has_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> pend_q);
  assert_ovf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && pend_q && !clr) |=> ovf_q);
endmodule

// File: rtl/evcap_dual.sv
module evcap_dual
  import evcap_pkg::*;
#(
  parameter int NPINS   = 12,
  parameter int STAMP_W = 32,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  input  logic [NPINS-1:0]   gpio_in,
  input  logic [STAMP_W-1:0] timer_val,
  input  logic [STAMP_W-1:0] rtc_val,
  input  logic [1:0]         clr_pend,
  output logic [STAMP_W-1:0] cap0,
  output logic [STAMP_W-1:0] cap1,
  output logic [1:0]         pend,
  output logic [1:0]         ovf,
  output logic               irq
);
  localparam int NCH  = 2;
  localparam int CW_W = NCH * CFG_W;

  logic [CW_W-1:0]    cfg_q;
  logic [31:CW_W]     rsvd_unused;
  logic [NPINS-1:0]   pin_rise, pin_fall;
  logic [STAMP_W-1:0] cap_a [NCH];
  logic [NCH-1:0]     ie;

  assign rsvd_unused = cfg_wdata[31:CW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[CW_W-1:0];
  end

  evcap_sync_bank #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in (gpio_in),
    .rise    (pin_rise),
    .fall    (pin_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t ccfg;
    assign ccfg  = chan_cfg_t'(cfg_q[c*CFG_W +: CFG_W]);
    assign ie[c] = ccfg.irq_en;

    evcap_channel #(.NPINS(NPINS), .STAMP_W(STAMP_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (ccfg),
      .cfg_we    (cfg_we),
      .pin_rise  (pin_rise),
      .pin_fall  (pin_fall),
      .timer_val (timer_val),
      .rtc_val   (rtc_val),
      .clr       (clr_pend[c]),
      .cap_q     (cap_a[c]),
      .pend_q    (pend[c]),
      .ovf_q     (ovf[c])
    );
  end

  assign cap0 = cap_a[0];
  assign cap1 = cap_a[1];
  assign irq  = |(pend & ie);

  // R10: with nothing pending the interrupt stays low
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);
endmodule

// File: tb/evcap_dual_bench.sv
module evcap_dual_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] gpio_in = '0;
  logic [31:0] timer_val = '0;
  logic [31:0] rtc_val = '0;
  logic [1:0]  clr_pend = '0;
  logic [31:0] cap0, cap1;
  logic [1:0]  pend, ovf;
  logic        irq;

  int checks = 0;
  int errors = 0;

  typedef struct { int ch; logic [31:0] val; } exp_t;
  exp_t exp_q[$];
  logic [1:0] prev_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evcap_dual u_evcap_dual (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gpio_in(gpio_in), .timer_val(timer_val), .rtc_val(rtc_val),
    .clr_pend(clr_pend), .cap0(cap0), .cap1(cap1), .pend(pend),
    .ovf(ovf), .irq(irq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // channel slice: {rtc, pmax[5:0], ie, count, fall, sel[3:0]}
  function automatic logic [13:0] mk(input logic [3:0] sel, input logic fall,
      input logic cnt, input logic ie, input logic [5:0] pmax, input logic rtc);
    return {rtc, pmax, ie, cnt, fall, sel};
  endfunction

  task automatic wr_cfg(input logic [13:0] a, input logic [13:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {4'hF, b, a};   // top bits must be ignored (R1)
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int ch, input logic [31:0] v);
    exp_t e;
    e.ch = ch; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic clr(input int ch);
    @(negedge clk);
    clr_pend[ch] = 1'b1;
    @(negedge clk);
    clr_pend = '0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int pin);
    @(negedge clk);
    gpio_in[pin] = 1'b1;
    waitn(4);
    gpio_in[pin] = 1'b0;
    waitn(4);
  endtask

  // monitor: each rising pending flag consumes one expected event
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (pend[c] && !prev_pend[c]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R4/R7 unexpected event", c, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.ch == c, "R5 event channel", c, e.ch);
            chk((c == 0 ? cap0 : cap1) == e.val, "R5/R6 stored stamp",
                c == 0 ? cap0 : cap1, e.val);
          end
        end
      end
    end
    prev_pend <= pend;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pend == 0 && ovf == 0 && !irq, "R2 reset flags", {pend, ovf, irq}, 0);
    chk(cap0 == 0 && cap1 == 0, "R2 reset stamps", cap0 | cap1, 0);

    // R1 R5 R10: ch0 on gpio2 (sel 3), rising, capture, irq on, timer stamp
    timer_val = 32'h111; rtc_val = 32'hA0A0;
    wr_cfg(mk(4'd3, 0, 0, 1, 6'd0, 0), mk(4'd0, 0, 0, 0, 6'd0, 0));
    push(0, 32'h111);
    gpio_in[2] = 1'b1;            // driven before edge k
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(pend[0] == 0, "R5 not before k+2", pend[0], 0);
    @(posedge clk); @(negedge clk);
    chk(pend[0] == 1, "R5 pending at k+2", pend[0], 1);
    chk(irq == 1, "R10 irq with enable", irq, 1);
    clr(0);
    chk(pend[0] == 0 && irq == 0, "R9 clear drops flag", {pend[0], irq}, 0);
    gpio_in[2] = 1'b0;
    waitn(5);
    chk(pend[0] == 0, "R4 falling ignored in rising mode", pend[0], 0);

    // R11 overflow
    timer_val = 32'h222; push(0, 32'h222);
    pulse(2);
    timer_val = 32'h333;
    pulse(2);
    chk(ovf[0] == 1, "R11 overflow set", ovf[0], 1);
    chk(cap0 == 32'h333, "R11 stamp overwritten", cap0, 32'h333);
    clr(0);
    chk(pend[0] == 0 && ovf[0] == 0, "R11 clear drops overflow", {pend[0], ovf[0]}, 0);

    // R4 R6: falling edge, rtc stamp (select changed via code 0 first)
    wr_cfg(mk(4'd0, 1, 0, 1, 6'd0, 1), 14'd0);
    wr_cfg(mk(4'd3, 1, 0, 1, 6'd0, 1), 14'd0);
    push(0, 32'hA0A0);
    pulse(2);
    chk(pend[0] == 1, "R4 falling edge event", pend[0], 1);
    clr(0);

    // R3 unused codes
    wr_cfg(mk(4'd13, 0, 0, 1, 6'd0, 0), 14'd0);
    pulse(2); pulse(11);
    chk(pend == 0, "R3 code 13 unused", pend, 0);
    wr_cfg(mk(4'd15, 0, 0, 1, 6'd0, 0), 14'd0);
    pulse(2); pulse(11);
    chk(pend == 0, "R3 code 15 unused", pend, 0);
    wr_cfg(mk(4'd0, 0, 0, 1, 6'd0, 0), 14'd0);
    pulse(2);
    chk(pend == 0 && cap0 == 32'hA0A0, "R3 code 0 unused", cap0, 32'hA0A0);

    // R3 boundary: code 12 routes gpio11
    wr_cfg(mk(4'd12, 0, 0, 1, 6'd0, 0), 14'd0);
    timer_val = 32'h444;
    pulse(2);
    chk(pend[0] == 0, "R3 code 12 not gpio2", pend[0], 0);
    push(0, 32'h444);
    pulse(11);
    clr(0);

    // R10 R3: ch1 code 1 (gpio0), irq disabled
    wr_cfg(14'd0, mk(4'd1, 0, 0, 0, 6'd0, 0));
    timer_val = 32'h555; push(1, 32'h555);
    pulse(0);
    chk(pend[1] == 1 && irq == 0, "R10 masked irq", {pend[1], irq}, 2'b10);
    chk(pend[0] == 0, "R3 ch0 idle", pend[0], 0);
    clr(1);

    // R7 count mode N=2
    wr_cfg(14'd0, mk(4'd1, 0, 1, 1, 6'd2, 0));
    timer_val = 32'h666;
    pulse(0); pulse(0);
    chk(pend[1] == 0, "R7 no event before N+1", pend[1], 0);
    push(1, 32'h666);
    pulse(0);
    chk(irq == 1, "R10 irq on count event", irq, 1);
    clr(1);
    pulse(0); pulse(0);
    chk(pend[1] == 0, "R7 restart after event", pend[1], 0);
    push(1, 32'h666);
    pulse(0);
    clr(1);

    // R8 control write clears the count
    pulse(0); pulse(0);
    wr_cfg(14'd0, mk(4'd1, 0, 1, 1, 6'd2, 0));
    pulse(0); pulse(0);
    chk(pend[1] == 0, "R8 count cleared by write", pend[1], 0);
    push(1, 32'h666);
    pulse(0);
    clr(1);

    // R7 boundary N=0
    wr_cfg(14'd0, mk(4'd1, 0, 1, 1, 6'd0, 1));
    rtc_val = 32'h777; push(1, 32'h777);
    pulse(0);
    clr(1);
    rtc_val = 32'h778; push(1, 32'h778);
    pulse(0);
    clr(1);

    waitn(3);
    chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule